// File: doc/BRIEF.md
# H-Bridge Gate Control Core with Dead-Time Insertion

This block is the synchronous digital core of a full-bridge gate driver. It turns a small set of control inputs into four gate enables: the high-side and low-side switch of leg A and of leg B. A direction input picks which leg sources current from the supply and which sinks it to ground. Two PWM inputs chop the high-side switch, the low-side switch, or both. A synchronous-rectification input decides whether the complementary switch of a chopped switch is turned on during PWM off time or left off so the body diode carries the current. Sleep, coast and brake controls override the normal decode.

Every control input passes through a two-flop synchroniser and a three-sample majority vote, which rejects single-cycle glitches. Each leg then enforces break-before-make. When a leg moves from one switch to its complement, both gates of that leg stay off for a programmable number of clock cycles. Writing zero to the dead-time input selects a build-time default of DEF_DEAD cycles. The default parameters give 300 cycles, which is 6 us at 50 MHz.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With sleep, coast and brake low and both PWM inputs high, `dir_i` = 1 turns on `gate_ah_o` and `gate_bl_o`, and `dir_i` = 0 turns on `gate_bh_o` and `gate_al_o`. All other gates stay off.
- R2: When `pwm_hs_i` is low and `pwm_ls_i` is high, the high-side gate of the driving leg is off. With `sync_rect_i` = 0 that leg is fully off. With `sync_rect_i` = 1 that leg's low-side gate is on. The sinking leg's low-side gate stays on.
- R3: When `pwm_ls_i` is low and `pwm_hs_i` is high, the low-side gate of the sinking leg is off. With `sync_rect_i` = 0 that leg is fully off. With `sync_rect_i` = 1 that leg's high-side gate is on. The driving leg's high-side gate stays on.
- R4: When both PWM inputs are low, the bridge is in fast decay. With `sync_rect_i` = 0 all four gates are off. With `sync_rect_i` = 1 the driving leg's low-side gate and the sinking leg's high-side gate are on.
- R5: `sleep_i` high forces all four gates off, whatever the other inputs are.
- R6: `coast_i` high with `sleep_i` low forces all four gates off, and it overrides `brake_i`.
- R7: `brake_i` high with sleep and coast low turns on both low-side gates and no high-side gate. A leg whose high-side gate was on passes through the full dead time first.
- R8: The high-side and low-side gates of one leg are never on in the same clock cycle.
- R9: When a leg turns on the switch complementary to the one that last conducted, both of its gates have been off for at least D cycles. A request held steady gives exactly D cycles. A leg whose request reverts to the last-conducting switch may turn it back on at once, and a later complementary turn-on again needs D fresh off cycles.
- R10: D equals `dead_cycles_i` when that input is non-zero, and equals DEF_DEAD when it is zero.
- R11: A control input pulse that lasts one clock cycle has no effect on the gates. A held change first shows at the gates on the 6th rising clock edge after it is applied, provided no dead time is pending.
- R12: While `rst` is high, all four gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | Direction: 1 = leg A drives high and leg B sinks; 0 = the reverse |
| pwm_hs_i | input | 1 | High-side chop input; low = off time for the driving high-side switch |
| pwm_ls_i | input | 1 | Low-side chop input; low = off time for the sinking low-side switch |
| sync_rect_i | input | 1 | Enables synchronous rectification during off time |
| sleep_i | input | 1 | Forces all gates off |
| coast_i | input | 1 | Forces all gates off while awake |
| brake_i | input | 1 | Turns on both low-side gates |
| dead_cycles_i | input | DT_W | Dead time in cycles; 0 selects DEF_DEAD |
| gate_ah_o | output | 1 | Leg A high-side gate enable |
| gate_al_o | output | 1 | Leg A low-side gate enable |
| gate_bh_o | output | 1 | Leg B high-side gate enable |
| gate_bl_o | output | 1 | Leg B low-side gate enable |

## Verification
The bench builds the block with DT_W = 8 and DEF_DEAD = 12 rather than 300 cycles. With these values the zero-means-default path finishes within a few dozen cycles, so every one of the 128 control combinations, and several hundred random ones with programmed dead times of 1 to 20 cycles, fits in a short run. The narrow counter also lets the bench set dead times long enough to reverse a request in the middle of the off window. That exercises both the immediate return to the same switch and the fresh dead time that follows.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Per-leg conduction state
  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_e;

  // Filtered control word
  typedef struct packed {
    logic sleep;
    logic coast;
    logic brake;
    logic sr;
    logic pwm_ls;
    logic pwm_hs;
    logic dir;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/hbg_input_filter.sv
module hbg_input_filter #(
  parameter int WIDTH       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] clean_o
);

  localparam int VOTE_N = 3;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_N-1:0]      hist_q;
    logic                   vote;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i[b]};
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        hist_q <= '0;
      end else begin
        hist_q <= {hist_q[VOTE_N-2:0], sync_q[SYNC_STAGES-1]};
      end
    end

    // two out of three
    assign vote = (hist_q[0] & hist_q[1]) | (hist_q[1] & hist_q[2]) |
                  (hist_q[0] & hist_q[2]);

    always_ff @(posedge clk) begin
      if (rst) begin
        clean_o[b] <= 1'b0;
      end else begin
        clean_o[b] <= vote;
      end
    end
  end

endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
  import hbg_pkg::*;
(
  input  ctrl_t ctrl_i,
  output leg_e  req_a_o,
  output leg_e  req_b_o
);

  leg_e src_req;   // leg connected toward the supply
  leg_e snk_req;   // leg connected toward ground

  always_comb begin
    // source leg: high-side unless chopped, then rectify low or float
    if (ctrl_i.pwm_hs)   src_req = LEG_HIGH;
    else if (ctrl_i.sr)  src_req = LEG_LOW;
    else                 src_req = LEG_OFF;
    // sink leg: low-side unless chopped, then rectify high or float
    if (ctrl_i.pwm_ls)   snk_req = LEG_LOW;
    else if (ctrl_i.sr)  snk_req = LEG_HIGH;
    else                 snk_req = LEG_OFF;
  end

  always_comb begin
    if (ctrl_i.sleep || ctrl_i.coast) begin
      req_a_o = LEG_OFF;
      req_b_o = LEG_OFF;
    end else if (ctrl_i.brake) begin
      req_a_o = LEG_LOW;
      req_b_o = LEG_LOW;
    end else if (ctrl_i.dir) begin
      req_a_o = src_req;
      req_b_o = snk_req;
    end else begin
      req_a_o = snk_req;
      req_b_o = src_req;
    end
  end

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int DT_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  leg_e            req_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            gate_h_o,
  output logic            gate_l_o
);

  localparam logic [DT_W-1:0] IDLE_MAX = '1;

  leg_e            cur_q;
  leg_e            last_q;
  logic [DT_W-1:0] idle_q;
  logic [DT_W-1:0] dead_m1;
  logic            may_on;

  assign dead_m1 = dead_i - 1'b1;
  assign may_on  = (last_q == req_i) || (last_q == LEG_OFF) || (idle_q >= dead_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= LEG_OFF;
      last_q <= LEG_OFF;
      idle_q <= IDLE_MAX;
    end else if (cur_q != LEG_OFF) begin
      last_q <= cur_q;
      idle_q <= '0;
      if (req_i != cur_q) begin
        cur_q <= LEG_OFF;
      end
    end else begin
      if (idle_q != IDLE_MAX) begin
        idle_q <= idle_q + 1'b1;
      end
      if (req_i != LEG_OFF && may_on) begin
        cur_q <= req_i;
      end
    end
  end

  assign gate_h_o = (cur_q == LEG_HIGH);
  assign gate_l_o = (cur_q == LEG_LOW);

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int DT_W     = 16,
  parameter int DEF_DEAD = 300
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dir_i,
  input  logic            pwm_hs_i,
  input  logic            pwm_ls_i,
  input  logic            sync_rect_i,
  input  logic            sleep_i,
  input  logic            coast_i,
  input  logic            brake_i,
  input  logic [DT_W-1:0] dead_cycles_i,
  output logic            gate_ah_o,
  output logic            gate_al_o,
  output logic            gate_bh_o,
  output logic            gate_bl_o
);

  localparam logic [DT_W-1:0] DEAD_DFLT = DT_W'(DEF_DEAD);
  localparam int N_LEG = 2;

  ctrl_t           raw_ctrl;
  ctrl_t           flt_ctrl;
  logic [DT_W-1:0] dead_eff;
  leg_e            req [N_LEG];
  logic [N_LEG-1:0] g_hi;
  logic [N_LEG-1:0] g_lo;

  always_comb begin
    raw_ctrl.sleep  = sleep_i;
    raw_ctrl.coast  = coast_i;
    raw_ctrl.brake  = brake_i;
    raw_ctrl.sr     = sync_rect_i;
    raw_ctrl.pwm_ls = pwm_ls_i;
    raw_ctrl.pwm_hs = pwm_hs_i;
    raw_ctrl.dir    = dir_i;
  end

  assign dead_eff = (dead_cycles_i == '0) ? DEAD_DFLT : dead_cycles_i;

  hbg_input_filter #(
    .WIDTH       (CTRL_W),
    .SYNC_STAGES (2)
  ) u_filter (
    .clk     (clk),
    .rst     (rst),
    .raw_i   (raw_ctrl),
    .clean_o (flt_ctrl)
  );

  hbg_decode u_decode (
    .ctrl_i  (flt_ctrl),
    .req_a_o (req[0]),
    .req_b_o (req[1])
  );

  for (genvar l = 0; l < N_LEG; l++) begin : g_leg
    hbg_leg #(
      .DT_W (DT_W)
    ) u_leg (
      .clk      (clk),
      .rst      (rst),
      .req_i    (req[l]),
      .dead_i   (dead_eff),
      .gate_h_o (g_hi[l]),
      .gate_l_o (g_lo[l])
    );
  end

  assign gate_ah_o = g_hi[0];
  assign gate_al_o = g_lo[0];
  assign gate_bh_o = g_hi[1];
  assign gate_bl_o = g_lo[1];

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int DT_W     = 16,
  parameter int DEF_DEAD = 300
) (
  input logic            clk,
  input logic            rst,
  input logic            sleep_i,
  input logic            coast_i,
  input logic [DT_W-1:0] dead_cycles_i,
  input logic            gate_ah_o,
  input logic            gate_al_o,
  input logic            gate_bh_o,
  input logic            gate_bl_o
);

  localparam int CW = DT_W + 1;
  localparam logic [CW-1:0] CMAX = '1;
  localparam int HOLD_N = 6;

  logic [CW-1:0] off_a, off_b;
  logic [1:0]    last_a, last_b;   // 0 none, 1 high, 2 low
  logic [CW-1:0] dead_q;
  logic [3:0]    slp_cnt, cst_cnt;
  logic          all_off;

  assign all_off = !(gate_ah_o | gate_al_o | gate_bh_o | gate_bl_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_a <= CMAX; off_b <= CMAX; last_a <= 2'd0; last_b <= 2'd0;
      dead_q <= CW'(DEF_DEAD); slp_cnt <= '0; cst_cnt <= '0;
    end else begin
      dead_q <= (dead_cycles_i == '0) ? CW'(DEF_DEAD) : CW'(dead_cycles_i);
      if (gate_ah_o) begin last_a <= 2'd1; off_a <= '0; end
      else if (gate_al_o) begin last_a <= 2'd2; off_a <= '0; end
      else if (off_a != CMAX) off_a <= off_a + 1'b1;
      if (gate_bh_o) begin last_b <= 2'd1; off_b <= '0; end
      else if (gate_bl_o) begin last_b <= 2'd2; off_b <= '0; end
      else if (off_b != CMAX) off_b <= off_b + 1'b1;
      slp_cnt <= sleep_i ? ((slp_cnt == 4'hF) ? slp_cnt : slp_cnt + 1'b1) : '0;
      cst_cnt <= coast_i ? ((cst_cnt == 4'hF) ? cst_cnt : cst_cnt + 1'b1) : '0;
    end
  end

  // R8
  leg_a_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_ah_o && gate_al_o));

  // R8
  leg_b_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_bh_o && gate_bl_o));

  // R9
  leg_a_dead_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_al_o && last_a == 2'd1) |-> (off_a >= dead_q));

  // R9
  leg_a_dead_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_ah_o && last_a == 2'd2) |-> (off_a >= dead_q));

  // R9
  leg_b_dead_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_bl_o && last_b == 2'd1) |-> (off_b >= dead_q));

  // R9
  leg_b_dead_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_bh_o && last_b == 2'd2) |-> (off_b >= dead_q));

  // R5
  sleep_all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (slp_cnt >= 4'(HOLD_N)) |-> all_off);

  // R6
  coast_all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cst_cnt >= 4'(HOLD_N)) |-> all_off);

  // R12
  reset_all_off_chk: assert property (@(posedge clk)
    rst |=> all_off);

endmodule

bind hbridge_gate_ctrl hbg_checker #(
  .DT_W     (DT_W),
  .DEF_DEAD (DEF_DEAD)
) u_hbg_checker (
  .clk           (clk),
  .rst           (rst),
  .sleep_i       (sleep_i),
  .coast_i       (coast_i),
  .dead_cycles_i (dead_cycles_i),
  .gate_ah_o     (gate_ah_o),
  .gate_al_o     (gate_al_o),
  .gate_bh_o     (gate_bh_o),
  .gate_bl_o     (gate_bl_o)
);

// File: tb/hbridge_gate_ctrl_bench.sv
module hbridge_gate_ctrl_bench;

  localparam int DT_W     = 8;
  localparam int DEF_DEAD = 12;
  localparam int SETTLE   = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_i = 0, pwm_hs_i = 0, pwm_ls_i = 0, sync_rect_i = 0;
  logic sleep_i = 1, coast_i = 0, brake_i = 0;
  logic [DT_W-1:0] dead_cycles_i = 8'd4;
  logic gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cur_dead = 4;
  int off_a = 1000, off_b = 1000;
  int last_a = 0, last_b = 0;   // 0 none, 1 high, 2 low
  int gap_a = -1, gap_b = -1;

  always #10 clk = ~clk;   // 50 MHz

  hbridge_gate_ctrl #(.DT_W(DT_W), .DEF_DEAD(DEF_DEAD)) u_hbridge_gate_ctrl (
    .clk(clk), .rst(rst), .dir_i(dir_i), .pwm_hs_i(pwm_hs_i), .pwm_ls_i(pwm_ls_i),
    .sync_rect_i(sync_rect_i), .sleep_i(sleep_i), .coast_i(coast_i),
    .brake_i(brake_i), .dead_cycles_i(dead_cycles_i),
    .gate_ah_o(gate_ah_o), .gate_al_o(gate_al_o),
    .gate_bh_o(gate_bh_o), .gate_bl_o(gate_bl_o));

  function automatic logic [3:0] gates();
    return {gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o};
  endfunction

  // expected {ah, al, bh, bl}; ctrl = {sleep,coast,brake,sr,pwm_ls,pwm_hs,dir}
  function automatic logic [3:0] ref_gates(input logic [6:0] c);
    logic [1:0] src, snk;  // {high, low}
    if (c[6] || c[5]) return 4'b0000;
    if (c[4]) return 4'b0101;
    src = c[1] ? 2'b10 : (c[3] ? 2'b01 : 2'b00);
    snk = c[2] ? 2'b01 : (c[3] ? 2'b10 : 2'b00);
    return c[0] ? {src, snk} : {snk, src};
  endfunction

  function automatic string tag_of(input logic [6:0] c);
    if (c[6]) return "R5";
    if (c[5]) return "R6";
    if (c[4]) return "R7";
    if (c[1] && c[2]) return "R1";
    if (!c[1] && c[2]) return "R2";
    if (c[1] && !c[2]) return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [6:0] c);
    {sleep_i, coast_i, brake_i, sync_rect_i, pwm_ls_i, pwm_hs_i, dir_i} = c;
  endtask

  task automatic set_dead(input int d);
    dead_cycles_i = DT_W'(d);
    cur_dead = (d == 0) ? DEF_DEAD : d;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // continuous monitor: exclusivity (R8) and dead-time gaps (R9)
  always @(negedge clk) begin
    if (!rst) begin
      if (gate_ah_o && gate_al_o) check("R8 leg A", 1, 0);
      if (gate_bh_o && gate_bl_o) check("R8 leg B", 1, 0);
      if (gate_ah_o || gate_al_o) begin
        if ((gate_ah_o && last_a == 2) || (gate_al_o && last_a == 1)) begin
          gap_a = off_a;
          check("R9 leg A gap>=D", (off_a >= cur_dead) ? 1 : 0, 1);
        end
        last_a = gate_ah_o ? 1 : 2; off_a = 0;
      end else off_a++;
      if (gate_bh_o || gate_bl_o) begin
        if ((gate_bh_o && last_b == 2) || (gate_bl_o && last_b == 1)) begin
          gap_b = off_b;
          check("R9 leg B gap>=D", (off_b >= cur_dead) ? 1 : 0, 1);
        end
        last_b = gate_bh_o ? 1 : 2; off_b = 0;
      end else off_b++;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    bit ok;
    void'($urandom(32'h5EED_0042));
    // R12: reset state
    wait_n(3);
    apply(7'b0000111);
    wait_n(3);
    check("R12 gates in reset", gates(), 0);
    rst = 1'b0;
    wait_n(2);

    // R11: latency from idle
    apply(7'b1000000); wait_n(SETTLE);
    apply(7'b0000111);
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 5) check("R11 no change before edge 6", gate_ah_o, 0);
      if (k == 6) check("R11 change at edge 6", gate_ah_o, 1);
    end
    wait_n(SETTLE);

    // R11: single-cycle glitch ignored
    pwm_hs_i = 1'b0; @(negedge clk); pwm_hs_i = 1'b1;
    ok = 1;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (gates() != 4'b1001) ok = 0;
    end
    check("R11 one-cycle pulse ignored", ok, 1);

    // R9/R10: exact programmed dead time
    set_dead(5); wait_n(SETTLE);
    apply(7'b0000110); wait_n(SETTLE);
    check("R9 exact gap leg A", gap_a, 5);
    check("R9 exact gap leg B", gap_b, 5);

    // R10: zero selects default
    set_dead(0); wait_n(4);
    apply(7'b0000111); wait_n(SETTLE);
    check("R10 default gap leg A", gap_a, DEF_DEAD);
    check("R10 default gap leg B", gap_b, DEF_DEAD);

    // R9: reversal inside the dead window
    set_dead(20); wait_n(SETTLE);
    apply(7'b0000110); wait_n(12);
    apply(7'b0000111); wait_n(8);
    check("R9 same switch returns early", gates(), 4'b1001);
    wait_n(SETTLE);
    apply(7'b0000110); wait_n(SETTLE);
    check("R9 fresh gap after reversal", gap_a, 20);

    // R7: brake waits the dead time on the leg that was high
    set_dead(5); apply(7'b0000111); wait_n(SETTLE);
    apply(7'b0010111); wait_n(SETTLE);
    check("R7 brake gap leg A", gap_a, 5);
    check("R7 brake pattern", gates(), 4'b0101);

    // exhaustive truth table
    for (int c = 0; c < 128; c++) begin
      apply(7'(c)); wait_n(SETTLE);
      check(tag_of(7'(c)), gates(), ref_gates(7'(c)));
    end

    // constrained random: mostly awake, random dead time
    for (int n = 0; n < 300; n++) begin
      logic [6:0] c;
      c = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 3) != 0) c[6:4] = 3'b000;
      if ($urandom_range(0, 4) == 0) set_dead($urandom_range(1, 20));
      apply(c); wait_n(SETTLE);
      check(tag_of(c), gates(), ref_gates(c));
    end

    finish_run();
  end

endmodule